// File: doc/BRIEF.md
# Table-Ratio Clock Enable Generator

This block sits in the source clock domain of a PLL and produces clock-enable pulses for five functional domains: processor, fast bus, slow bus, display device and memory. It also produces enables for a display pixel stream and a free-running timer. Each domain's ratio is not a binary value. It is a 4-bit index into a fixed set of non-power-of-two divisors.

Software writes new ratio indices into a control register. Those values stay pending until a commit request is made. The commit waits for a cycle in which all five domain counters reach terminal count together. At that cycle the new ratios load into every domain at once, so the domains keep their relative phase.

A gate register can stop any output. A stop or restart takes effect only at a period boundary of that output. The pixel divider uses its own 9-bit period value. When the PLL is reported off, every divided output fires on every cycle.

Top module: `ratio_clk_gen`

## Requirements
- R1: Ratio index values 0 to 9 divide by 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 respectively. A domain at divide-by-N gives exactly N/... one enable per N cycles, so a 96-cycle window holds 96/N pulses.
- R2: Index values 10 to 15 behave as divide-by-1.
- R3: The control register is at address 0. Its ratio fields are processor in bits 3:0, fast bus in 7:4, slow bus in 11:8, display device in 15:12 and memory in 19:16. A read returns the last written fields.
- R4: Ratio fields written with bit 20 clear stay pending and do not change any output rate.
- R5: Writing 1 to bit 20 requests a commit. All pending ratios load together in a cycle where all five domain counters are at terminal count. Bit 20 reads 1 while the request is outstanding and 0 once it is applied.
- R6: Each output is a single-cycle enable, one per period. Divide-by-1 gives an enable on every cycle.
- R7: The gate register is at address 1, bits 7:0. A 1 stops an output and a 0 lets it run. The bit assignments are: bit 0 processor, bit 1 fast bus, bit 2 slow bus, bit 3 timer, bit 4 memory, and bit 7 both display device and pixel. A change takes effect only at that output's period boundary.
- R8: The pixel period value is at address 2, bits 8:0. The pixel enable repeats every value+1 cycles, a range of 1 to 512. A new value applies at the next pixel boundary without a commit.
- R9: While pll_on is low, all five domain enables and the pixel enable fire every cycle. Gating still applies.
- R10: After reset, all ratio indices are 0, bit 20 is 0, the pixel value is 0 and all gate bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pll_on | input | 1 | PLL reported enabled; low forces undivided outputs |
| bus_addr | input | 2 | Register select: 0 control, 1 gate, 2 pixel |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| en_cpu | output | 1 | Processor clock enable |
| en_fast | output | 1 | Fast bus clock enable |
| en_slow | output | 1 | Slow bus clock enable |
| en_lcd | output | 1 | Display device clock enable |
| en_mem | output | 1 | Memory clock enable |
| en_pix | output | 1 | Pixel clock enable |
| en_timer | output | 1 | Timer clock enable |

## Verification
The assertions check several properties on every cycle. A cleared commit request must coincide with all five domain counters at terminal count. A bypassed PLL must hold every domain counter at terminal count. A reserved processor index must yield an enable every cycle. An enable must be followed by a gap unless the period is one.

The actual ratio values can only be shown by the bench, which counts pulses over 96-cycle windows for each table entry. The bench also shows that uncommitted writes leave rates unchanged and that phase is aligned after a commit. It measures the effect of gate bits on each output and the pixel range end points.

// File: rtl/rcg_pkg.sv
// Shared constants, register addresses and the ratio table for the
// table-ratio clock enable generator. Assumes 32-bit register access.
package rcg_pkg;
    localparam int NUM_DOM  = 5;   // processor, fast, slow, display, memory
    localparam int IDX_W    = 4;   // ratio index width per domain
    localparam int CNT_W    = 5;   // enough for divide-by-32
    localparam int PIX_W    = 9;   // pixel period field width
    localparam int GATE_W   = 8;   // gate register width
    localparam int DATA_W   = 32;  // bus data width
    localparam int FIELDS_W = NUM_DOM * IDX_W;
    localparam int UPD_BIT  = FIELDS_W; // commit request bit (20)

    // Gate bit per domain, in domain order
    localparam int DOM_GATE_BIT [NUM_DOM] = '{0, 1, 2, 7, 4};
    localparam int TIMER_GATE_BIT = 3;
    localparam int PIX_GATE_BIT   = 7;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_GATE = 2'd1,
        ADDR_PIX  = 2'd2,
        ADDR_NONE = 2'd3
    } addr_e;

    // Map a ratio index to (divisor - 1); reserved codes act as divide-by-1.
    function automatic logic [CNT_W-1:0] idx_to_pm1(input logic [IDX_W-1:0] idx);
        logic [CNT_W-1:0] r;
        case (idx)
            4'd0:    r = 5'd0;
            4'd1:    r = 5'd1;
            4'd2:    r = 5'd2;
            4'd3:    r = 5'd3;
            4'd4:    r = 5'd5;
            4'd5:    r = 5'd7;
            4'd6:    r = 5'd11;
            4'd7:    r = 5'd15;
            4'd8:    r = 5'd23;
            4'd9:    r = 5'd31;
            default: r = 5'd0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/rcg_regs.sv
// Register block: pending and active ratio fields, commit request flag,
// gate bits and pixel period. Active ratios load from pending only when
// the top asserts commit. Assumes single-cycle writes, combinational reads.
module rcg_regs
    import rcg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          addr,
    input  logic                we,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                commit,
    output logic [DATA_W-1:0]   rdata,
    output logic [FIELDS_W-1:0] act_idx,
    output logic                upd_q,
    output logic [GATE_W-1:0]   gate_q,
    output logic [PIX_W-1:0]    pix_q
);
    logic [FIELDS_W-1:0] pend_q;
    logic                wr_ctrl;
    logic                wr_gate;
    logic                wr_pix;

    assign wr_ctrl = we && (addr == ADDR_CTRL);
    assign wr_gate = we && (addr == ADDR_GATE);
    assign wr_pix  = we && (addr == ADDR_PIX);

    logic unused_wdata;
    assign unused_wdata = ^wdata[DATA_W-1:UPD_BIT+1];

    // Pending ratio fields, written directly by the bus
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= '0;
        else if (wr_ctrl) pend_q <= wdata[FIELDS_W-1:0];
    end

    // Commit request: set by a write of 1, cleared when applied
    always_ff @(posedge clk) begin
        if (!rst_n)                       upd_q <= 1'b0;
        else if (wr_ctrl && wdata[UPD_BIT]) upd_q <= 1'b1;
        else if (commit)                  upd_q <= 1'b0;
    end

    // Active ratio fields, loaded all together on commit
    always_ff @(posedge clk) begin
        if (!rst_n)      act_idx <= '0;
        else if (commit) act_idx <= pend_q;
    end

    // Gate bits
    always_ff @(posedge clk) begin
        if (!rst_n)       gate_q <= '0;
        else if (wr_gate) gate_q <= wdata[GATE_W-1:0];
    end

    // Pixel period value
    always_ff @(posedge clk) begin
        if (!rst_n)      pix_q <= '0;
        else if (wr_pix) pix_q <= wdata[PIX_W-1:0];
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr_e'(addr))
            ADDR_CTRL: rdata[UPD_BIT:0] = {upd_q, pend_q};
            ADDR_GATE: rdata[GATE_W-1:0] = gate_q;
            ADDR_PIX:  rdata[PIX_W-1:0]  = pix_q;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/rcg_counter.sv
// One divider: counts source cycles up to period_m1 and flags terminal
// count. The run flag is sampled only at terminal count, so a gate change
// never cuts a period short. Bypass forces terminal count every cycle.
module rcg_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bypass,
    input  logic [W-1:0] period_m1,
    input  logic         run_req,
    output logic         tc,
    output logic         en
);
    logic [W-1:0] cnt_q;
    logic         run_q;

    // Terminal count; >= guards a period shortened mid-count
    assign tc = bypass || (cnt_q >= period_m1);
    assign en = tc && run_q;

    // Cycle counter, restarts after terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || tc) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // Run flag, updated only at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)  run_q <= 1'b1;
        else if (tc) run_q <= run_req;
    end
endmodule

// File: rtl/ratio_clk_gen.sv
// Top: five table-ratio domain dividers, a pixel divider and a timer
// enable, all in the source clock domain. The commit fires when a request
// is pending and every domain is at terminal count in the same cycle.
module ratio_clk_gen
    import rcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_on,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              en_cpu,
    output logic              en_fast,
    output logic              en_slow,
    output logic              en_lcd,
    output logic              en_mem,
    output logic              en_pix,
    output logic              en_timer
);
    logic [FIELDS_W-1:0]      act_idx;
    logic                     upd_q;
    logic [GATE_W-1:0]        gate_q;
    logic [PIX_W-1:0]         pix_q;
    logic                     commit;
    logic [NUM_DOM-1:0]       dom_tc;
    logic [NUM_DOM-1:0]       dom_en;
    logic [NUM_DOM*CNT_W-1:0] dom_pm1;
    logic                     pix_tc;
    logic                     tmr_tc;
    logic                     bypass;

    assign bypass = !pll_on;
    assign commit = upd_q && (&dom_tc);

    rcg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .commit  (commit),
        .rdata   (bus_rdata),
        .act_idx (act_idx),
        .upd_q   (upd_q),
        .gate_q  (gate_q),
        .pix_q   (pix_q)
    );

    // One divider per ratio domain
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        assign dom_pm1[d*CNT_W +: CNT_W] = idx_to_pm1(act_idx[d*IDX_W +: IDX_W]);
        rcg_counter #(.W(CNT_W)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .bypass    (bypass),
            .period_m1 (dom_pm1[d*CNT_W +: CNT_W]),
            .run_req   (!gate_q[DOM_GATE_BIT[d]]),
            .tc        (dom_tc[d]),
            .en        (dom_en[d])
        );
    end

    rcg_counter #(.W(PIX_W)) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass    (bypass),
        .period_m1 (pix_q),
        .run_req   (!gate_q[PIX_GATE_BIT]),
        .tc        (pix_tc),
        .en        (en_pix)
    );

    rcg_counter #(.W(1)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bypass    (1'b0),
        .period_m1 (1'b0),
        .run_req   (!gate_q[TIMER_GATE_BIT]),
        .tc        (tmr_tc),
        .en        (en_timer)
    );

    logic unused_tc;
    assign unused_tc = pix_tc ^ tmr_tc;

    assign en_cpu  = dom_en[0];
    assign en_fast = dom_en[1];
    assign en_slow = dom_en[2];
    assign en_lcd  = dom_en[3];
    assign en_mem  = dom_en[4];
endmodule

// File: rtl/rcg_checks.sv
// Checker for ratio_clk_gen: commit alignment, bypass, pulse spacing and
// reserved-index behaviour. Attached by bind below.
module rcg_checks
    import rcg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               pll_on,
    input logic               upd_q,
    input logic [NUM_DOM-1:0] dom_tc,
    input logic [IDX_W-1:0]   cpu_idx,
    input logic [CNT_W-1:0]   cpu_pm1
);
    // R5: a request clears only in a cycle where every domain was at terminal count
    a_r5_commit_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_q) |-> $past(&dom_tc));

    // R9: with the PLL off every domain fires each cycle
    a_r9_bypass_all: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_on |-> (&dom_tc));

    // R6: a processor pulse is followed by a gap unless the period is one
    a_r6_one_per_period: assert property (@(posedge clk) disable iff (!rst_n)
        dom_tc[0] |=> (!dom_tc[0] || !pll_on || cpu_pm1 == '0));

    // R2: reserved processor index behaves as divide-by-1
    a_r2_reserved_div1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_idx >= 4'd10) |-> dom_tc[0]);
endmodule

bind ratio_clk_gen rcg_checks u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pll_on  (pll_on),
    .upd_q   (upd_q),
    .dom_tc  (dom_tc),
    .cpu_idx (act_idx[rcg_pkg::IDX_W-1:0]),
    .cpu_pm1 (dom_pm1[rcg_pkg::CNT_W-1:0])
);

// File: tb/ratio_clk_gen_tb.sv
// Scoreboard bench: the driver queues expected pulse counts per output and
// window; a monitor counts pulses at negative edges and compares.
module ratio_clk_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pll_on = 1'b1;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic en_cpu, en_fast, en_slow, en_lcd, en_mem, en_pix, en_timer;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 0;

    typedef struct {
        int    dom;
        int    win;
        int    exp;
        string tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk; // 200 MHz

    ratio_clk_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pll_on(pll_on),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .en_cpu(en_cpu), .en_fast(en_fast), .en_slow(en_slow),
        .en_lcd(en_lcd), .en_mem(en_mem), .en_pix(en_pix), .en_timer(en_timer)
    );

    // 0 cpu,1 fast,2 slow,3 lcd,4 mem,5 pix,6 timer,7 cpu&mem,8 slow&lcd
    function automatic logic sel(input int d);
        case (d)
            0: return en_cpu;
            1: return en_fast;
            2: return en_slow;
            3: return en_lcd;
            4: return en_mem;
            5: return en_pix;
            6: return en_timer;
            7: return en_cpu && en_mem;
            8: return en_slow && en_lcd;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ctrl(input int c, f, s, l, m, input bit upd);
        return {11'd0, upd, m[3:0], l[3:0], s[3:0], f[3:0], c[3:0]};
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (200) @(negedge clk);
    endtask

    // Driver side: queue an expectation and wait for the monitor
    task automatic expect_rate(input int dom, input int win, input int exp, input string tag);
        item_t it;
        int tgt;
        it.dom = dom; it.win = win; it.exp = exp; it.tag = tag;
        tgt = done_cnt + 1;
        q.push_back(it);
        wait (done_cnt >= tgt);
    endtask

    // Monitor: count pulses over each queued window
    initial begin
        forever begin
            item_t it;
            int n;
            wait (q.size() != 0);
            it = q.pop_front();
            n = 0;
            for (int i = 0; i < it.win; i++) begin
                @(negedge clk);
                if (sel(it.dom)) n++;
            end
            check(it.tag, n, it.exp);
            done_cnt++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        bus_read(2'd0, rd); check("R10 ctrl reset", rd, 0);
        bus_read(2'd1, rd); check("R10 gate reset", rd, 0);
        bus_read(2'd2, rd); check("R10 pixel reset", rd, 0);
        expect_rate(0, 96, 96, "R6 R10 cpu div1 every cycle");
        expect_rate(5, 96, 96, "R10 pixel div1");

        // R1 R5: commit indices 1,2,4,7,9 -> 2,3,6,16,32
        bus_write(2'd0, ctrl(1, 2, 4, 7, 9, 1));
        settle();
        bus_read(2'd0, rd); check("R5 request cleared", rd, ctrl(1, 2, 4, 7, 9, 0));
        expect_rate(0, 96, 48, "R1 cpu idx1");
        expect_rate(1, 96, 32, "R1 fast idx2");
        expect_rate(2, 96, 16, "R1 slow idx4");
        expect_rate(3, 96, 6,  "R1 lcd idx7");
        expect_rate(4, 96, 3,  "R1 mem idx9");
        expect_rate(7, 96, 3,  "R5 cpu/mem phase aligned");
        expect_rate(8, 96, 2,  "R5 slow/lcd phase aligned");

        // R3 R4: pending write without request
        bus_write(2'd0, ctrl(3, 5, 6, 8, 0, 0));
        bus_read(2'd0, rd); check("R3 field readback", rd, ctrl(3, 5, 6, 8, 0, 0));
        settle();
        expect_rate(0, 96, 48, "R4 cpu unchanged while pending");
        expect_rate(4, 96, 3,  "R4 mem unchanged while pending");

        // R1: commit indices 3,5,6,8,0 -> 4,8,12,24,1
        bus_write(2'd0, ctrl(3, 5, 6, 8, 0, 1));
        settle();
        expect_rate(0, 96, 24, "R1 cpu idx3");
        expect_rate(1, 96, 12, "R1 fast idx5");
        expect_rate(2, 96, 8,  "R1 slow idx6");
        expect_rate(3, 96, 4,  "R1 lcd idx8");
        expect_rate(4, 96, 96, "R1 mem idx0");

        // R2: reserved indices
        bus_write(2'd0, ctrl(10, 15, 12, 8, 9, 1));
        settle();
        expect_rate(0, 96, 96, "R2 cpu idx10");
        expect_rate(1, 96, 96, "R2 fast idx15");
        expect_rate(2, 96, 96, "R2 slow idx12");
        expect_rate(4, 96, 3,  "R2 mem idx9 unaffected");

        // R7: gating
        bus_write(2'd1, 32'h81);
        bus_read(2'd1, rd); check("R7 gate readback", rd, 32'h81);
        settle();
        expect_rate(0, 96, 0,  "R7 cpu stopped");
        expect_rate(3, 96, 0,  "R7 lcd stopped");
        expect_rate(5, 96, 0,  "R7 pixel stopped");
        expect_rate(1, 96, 96, "R7 fast still running");
        expect_rate(6, 96, 96, "R7 timer running");
        bus_write(2'd1, 32'h18);
        settle();
        expect_rate(6, 96, 0,  "R7 timer stopped");
        expect_rate(4, 96, 0,  "R7 mem stopped");
        expect_rate(0, 96, 96, "R7 cpu restarted");
        expect_rate(3, 96, 4,  "R7 lcd restarted");
        bus_write(2'd1, 32'h0);
        settle();

        // R8: pixel divider
        bus_write(2'd2, 32'd3);
        bus_read(2'd2, rd); check("R8 pixel readback", rd, 3);
        settle();
        expect_rate(5, 96, 24, "R8 pixel value 3");
        bus_write(2'd2, 32'd511);
        settle();
        expect_rate(5, 1024, 2, "R8 pixel value 511");

        // R9: PLL off
        pll_on = 1'b0;
        settle();
        expect_rate(4, 96, 96, "R9 mem bypassed");
        expect_rate(3, 96, 96, "R9 lcd bypassed");
        expect_rate(5, 96, 96, "R9 pixel bypassed");
        bus_write(2'd1, 32'h1);
        settle();
        expect_rate(0, 96, 0,  "R9 gating under bypass");
        bus_write(2'd1, 32'h0);
        pll_on = 1'b1;
        settle();
        expect_rate(4, 96, 3,  "R9 mem divides again");

        finish_run();
    end
endmodule